// File: doc/BRIEF.md
# Auto-Increment Register Pointer

This block keeps the register pointer of a byte-oriented serial-bus peripheral. After the bus front end accepts the device address, it hands over the first data byte as a control byte together with a one-cycle load strobe. The pointer captures a 4-bit register index and a 3-bit increment mode from that byte. After every data byte that is read or written, a one-cycle byte-done strobe moves the index forward according to the mode. The access that raises the strobe uses the index that was current before the move.

Each increment mode has its own wrap window, given by a start value and an end value. An index inside the window runs up to the end value and then jumps back to the start value. An index that begins outside the window counts up plainly to the last implemented register (0xC), rolls over to 0x0, and reaches the window from below. A validity flag tells the front end whether the current index names an implemented register, so it can decide whether to acknowledge.

Top module: `aip_pointer`

## Requirements
- R1: While reset is high and in the first cycle after it, the pointer shows index 0x0, mode 3'b100 (control byte 0x80), and the validity flag is 1.
- R2: On a load strobe, the index takes control bits 3:0 and the mode takes control bits 7:5 on the next clock edge. Control bit 4 has no effect.
- R3: When mode bit 2 is 0 (modes 000, 001, 010, 011), a byte-done strobe leaves the index unchanged.
- R4: In mode 100, a byte-done strobe adds one to the index, and index 0xC goes to 0x0.
- R5: In mode 101, index 0x5 goes to 0x2 on a byte-done strobe. Other indices below 0xC add one.
- R6: In mode 110, index 0x7 goes to 0x6 on a byte-done strobe. Other indices below 0xC add one.
- R7: In mode 111, index 0x7 goes to 0x2 on a byte-done strobe. Other indices below 0xC add one.
- R8: In any increment mode, an index outside its window counts up plainly. Indices 0xC to 0xF, when they are not the window end, go to 0x0. Starting from control byte 0xE8, the pointer visits 08, 09, 0A, 0B, 0C, 00, 01 … 07, 02, 03 … 07, 02.
- R9: The validity flag is 1 exactly when the current index is 0xC or lower. It is 0 for 0xD, 0xE and 0xF.
- R10: When load and byte-done are high in the same cycle, the load wins and the control byte's index is taken as it is.
- R11: The mode output changes only on a load strobe. Byte-done strobes never alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | One-cycle strobe: capture ctrl_i |
| ctrl_i | input | 8 | Control byte: mode in 7:5, unused bit 4, index in 3:0 |
| done_i | input | 1 | One-cycle strobe: a data byte finished, advance the index |
| idx_o | output | 4 | Current register index |
| mode_o | output | 3 | Current increment mode |
| idx_ok_o | output | 1 | Current index is an implemented register (0x0 to 0xC) |

## Verification
If the index register holds a wrong value, idx_o shows it one clock after the load or byte-done edge that produced it. A wrong next-index decision appears at the first wrap point or at the first out-of-window start. A corrupted mode shows up directly on mode_o, and it also shows up indirectly through the next wrap, which goes to the wrong start value. For this reason the bench loads every mode with every start index and checks each step over more than a full lap. A fault in any window, rollover or hold path therefore shows up within about twenty strobes of the load that exposes it.

// File: rtl/aip_pkg.sv
package aip_pkg;
    localparam int IDX_W  = 4;
    localparam int MODE_W = 3;
    localparam int CTRL_W = IDX_W + 1 + MODE_W;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [MODE_W-1:0] {
        M_HOLD = 3'b000,
        M_RSV1 = 3'b001,
        M_RSV2 = 3'b010,
        M_RSV3 = 3'b011,
        M_ALL  = 3'b100,
        M_BRT  = 3'b101,
        M_GRP  = 3'b110,
        M_MIX  = 3'b111
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  spare;
        idx_t  idx;
    } ctrl_t;

    localparam idx_t  LAST_REG   = 4'hC;
    localparam ctrl_t RESET_CTRL = '{mode: M_ALL, spare: 1'b0, idx: 4'h0};

    function automatic logic steps(input mode_e m);
        return m[MODE_W-1];
    endfunction

    function automatic idx_t win_lo(input mode_e m);
        case (m)
            M_BRT:   return 4'h2;
            M_GRP:   return 4'h6;
            M_MIX:   return 4'h2;
            default: return 4'h0;
        endcase
    endfunction

    function automatic idx_t win_hi(input mode_e m);
        case (m)
            M_BRT:   return 4'h5;
            M_GRP:   return 4'h7;
            M_MIX:   return 4'h7;
            default: return LAST_REG;
        endcase
    endfunction
endpackage

// File: rtl/aip_next_idx.sv
module aip_next_idx
    import aip_pkg::*;
#(
    parameter idx_t LAST = LAST_REG
) (
    input  idx_t  cur_i,
    input  mode_e mode_i,
    output idx_t  nxt_o
);
    idx_t lo, hi;

    always_comb begin
        lo = win_lo(mode_i);
        hi = win_hi(mode_i);
        if (!steps(mode_i))
            nxt_o = cur_i;
        else if (cur_i == hi)
            nxt_o = lo;
        else if (cur_i >= LAST)
            nxt_o = '0;
        else
            nxt_o = cur_i + 1'b1;
    end
endmodule

// File: rtl/aip_state.sv
module aip_state
    import aip_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [CTRL_W-1:0]   ctrl_i,
    input  logic                done_i,
    input  idx_t                nxt_i,
    output idx_t                idx_o,
    output mode_e               mode_o
);
    ctrl_t q;
    ctrl_t in_c;

    assign in_c = ctrl_t'(ctrl_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_CTRL;
        end else if (load_i) begin
            q.mode  <= in_c.mode;
            q.spare <= 1'b0;
            q.idx   <= in_c.idx;
        end else if (done_i) begin
            q.idx <= nxt_i;
        end
    end

    assign idx_o  = q.idx;
    assign mode_o = q.mode;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (load_i && !rst) |=> (idx_o == $past(in_c.idx)) && (mode_o == $past(in_c.mode))); // R2
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !rst) |=> $stable(mode_o)); // R11
    AST_HOLD_IDX: assert property (@(posedge clk) disable iff (rst)
        (!rst && !load_i && done_i && !mode_o[MODE_W-1]) |=> $stable(idx_o)); // R3
endmodule

// File: rtl/aip_pointer.sv
module aip_pointer
    import aip_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  logic [7:0]  ctrl_i,
    input  logic        done_i,
    output logic [3:0]  idx_o,
    output logic [2:0]  mode_o,
    output logic        idx_ok_o
);
    idx_t  cur, nxt;
    mode_e mode;

    aip_state u_state (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .ctrl_i (ctrl_i),
        .done_i (done_i),
        .nxt_i  (nxt),
        .idx_o  (cur),
        .mode_o (mode)
    );

    aip_next_idx #(.LAST(LAST_REG)) u_next (
        .cur_i  (cur),
        .mode_i (mode),
        .nxt_o  (nxt)
    );

    assign idx_o    = cur;
    assign mode_o   = mode;
    assign idx_ok_o = (cur <= LAST_REG);

    AST_ALL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!rst && !load_i && done_i && mode_o == 3'b100 && idx_o == 4'hC) |=> idx_o == 4'h0); // R4
    AST_BRT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!rst && !load_i && done_i && mode_o == 3'b101 && idx_o == 4'h5) |=> idx_o == 4'h2); // R5
    AST_GRP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!rst && !load_i && done_i && mode_o == 3'b110 && idx_o == 4'h7) |=> idx_o == 4'h6); // R6
    AST_MIX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!rst && !load_i && done_i && mode_o == 3'b111 && idx_o == 4'h7) |=> idx_o == 4'h2); // R7
endmodule

// File: tb/tb_aip_pointer.sv
module tb_aip_pointer;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [7:0] ctrl_i = 8'h00;
    logic       done_i = 1'b0;
    logic [3:0] idx_o;
    logic [2:0] mode_o;
    logic       idx_ok_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    aip_pointer dut (
        .clk(clk), .rst(rst), .load_i(load_i), .ctrl_i(ctrl_i),
        .done_i(done_i), .idx_o(idx_o), .mode_o(mode_o), .idx_ok_o(idx_ok_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] model_next(input logic [3:0] i, input logic [2:0] m);
        int lo, hi;
        if (m < 3'd4) return i;                       // R3
        case (m)
            3'd5:    begin lo = 2; hi = 5;  end       // R5
            3'd6:    begin lo = 6; hi = 7;  end       // R6
            3'd7:    begin lo = 2; hi = 7;  end       // R7
            default: begin lo = 0; hi = 12; end       // R4
        endcase
        if (int'(i) == hi) return 4'(lo);
        if (int'(i) >= 12) return 4'd0;              // R8
        return 4'(int'(i) + 1);
    endfunction

    task automatic check(input string req, input logic [3:0] ei, input logic [2:0] em);
        logic eok;
        eok = (ei <= 4'hC);
        checks++;
        if (idx_o !== ei || mode_o !== em || idx_ok_o !== eok) begin
            errors++;
            $display("FAIL %s: idx=%h mode=%b ok=%b expected idx=%h mode=%b ok=%b",
                     req, idx_o, mode_o, idx_ok_o, ei, em, eok);
        end
    endtask

    task automatic cyc(input logic ld, input logic [7:0] c, input logic dn);
        @(negedge clk);
        load_i = ld; ctrl_i = c; done_i = dn;
        @(posedge clk);
        #1;
        load_i = 1'b0; done_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] ei;
        string tag;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 4'h0, 3'b100);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset", 4'h0, 3'b100);

        // exhaustive sweep: every mode, every start, bit 4 toggled
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 16; s++) begin
                cyc(1'b1, {3'(m), 1'(s), 4'(s)}, 1'b0);
                check("R2 load", 4'(s), 3'(m));          // also R9 via flag
                ei = 4'(s);
                for (int k = 0; k < STEPS; k++) begin
                    cyc(1'b0, 8'hFF, 1'b1);
                    ei = model_next(ei, 3'(m));
                    case (m)
                        4:       tag = "R4 all-wrap";
                        5:       tag = "R5 brightness-wrap";
                        6:       tag = "R6 group-wrap";
                        7:       tag = (s >= 8) ? "R8 outside-start" : "R7 mixed-wrap";
                        default: tag = "R3 hold";
                    endcase
                    check(tag, ei, 3'(m));               // R11 mode unchanged
                end
            end
        end

        // explicit 0xE8 sequence
        cyc(1'b1, 8'hE8, 1'b0);
        check("R8 E8 start", 4'h8, 3'b111);
        for (int k = 0; k < 4; k++) cyc(1'b0, 8'h00, 1'b1);
        check("R8 E8 reaches C", 4'hC, 3'b111);
        cyc(1'b0, 8'h00, 1'b1);
        check("R8 E8 rolls to 0", 4'h0, 3'b111);
        for (int k = 0; k < 7; k++) cyc(1'b0, 8'h00, 1'b1);
        check("R8 E8 reaches 7", 4'h7, 3'b111);
        cyc(1'b0, 8'h00, 1'b1);
        check("R8 E8 wraps to 2", 4'h2, 3'b111);

        // load and done together: load wins
        cyc(1'b1, 8'hA3, 1'b1);
        check("R10 load priority", 4'h3, 3'b101);
        cyc(1'b1, 8'h8D, 1'b1);
        check("R10 load priority reserved idx R9", 4'hD, 3'b100);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule